// File: doc/BRIEF.md
# Binary Decimal Character Converter

This block converts a small number between plain binary and a two-digit decimal form. The number sits in two fixed, adjacent character slots of an eight-character accumulator word. Each character is seven bits wide: four numeric bits, two zone bits and one parity bit. When `to_decimal` is 1, the six data bits of the low slot are read as an unsigned binary value. The tens digit is written to the high slot and the units digit to the low slot. When `to_decimal` is 0, the numeric field of the high slot (tens) and the numeric field of the low slot (units) are combined into a binary value, and that value is written back into the low slot.

A single `start` strobe launches a conversion. The whole rewritten accumulator appears on `acc_out` one clock later, together with a one-cycle `done` pulse. A sticky error flag reports a decimal-to-binary result that does not fit in six bits. It stays set until `clr_ovf` is asserted. The parity of both rewritten characters is regenerated, and every other character passes through unchanged.

Top module: `bdc_converter`

## Requirements
- R1: After reset, `acc_out` is all zero and both `done` and `ovf_flag` are 0.
- R2: A `start` sampled high on a clock edge loads the converted word into `acc_out` and drives `done` high for exactly the following cycle. Without `start`, `acc_out` keeps its value.
- R3: Character k occupies bits [7k+6:7k]. Within a character, bits [3:0] are numeric, [5:4] are zone and [6] is parity. The low slot is k=3 and the high slot is k=4. With `to_decimal`=1, the value v = low[5:0] gives high[3:0] = v/10 and low[3:0] = v mod 10, and the zone bits of both slots become 0.
- R4: With `to_decimal`=0, the result is r = 10*high[3:0] + low[3:0]. low[5:0] receives r mod 64, and high[5:0] becomes 0.
- R5: Digit fields above 9 are used at their raw binary weight (0..15) with no error indication, for example 15 and 15 give 165.
- R6: A decimal-to-binary conversion with r > 63 sets `ovf_flag` in the same cycle that `done` is high. The low slot then holds r mod 64.
- R7: `ovf_flag` stays set until `clr_ovf` is sampled high. If a setting conversion and `clr_ovf` fall on the same edge, the flag ends up set.
- R8: A binary-to-decimal conversion never changes `ovf_flag`.
- R9: After every conversion, bit [6] of both slots gives each seven-bit character an odd number of ones.
- R10: Every character other than slots 3 and 4 is copied unchanged from `acc_in` at the `start` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one conversion |
| to_decimal | input | 1 | 1 converts binary to decimal, 0 converts decimal to binary |
| clr_ovf | input | 1 | Clear the sticky overflow flag |
| acc_in | input | 56 | Accumulator word to convert |
| acc_out | output | 56 | Registered converted word |
| done | output | 1 | One-cycle pulse when `acc_out` has been updated |
| ovf_flag | output | 1 | Sticky decimal-to-binary overflow flag |

## Verification
On every cycle, the assertions check the following:
- the odd parity of both slots after a conversion;
- zone clearing in binary-to-decimal mode;
- clearing of the high slot in decimal-to-binary mode;
- the pass-through of the untouched characters;
- that `acc_out` is held between conversions;
- that the overflow flag only rises from a qualifying conversion and stays set until cleared.

The digit values themselves, the modulo-64 wrap, the raw weight of digits above 9 and the priority of set over clear are shown only by the bench's scenarios. These scenarios compare `acc_out` against independently computed words for random and edge operands.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int DATA_BITS = 6;
  localparam int NUM_BITS  = 4;
  localparam int CHAR_W    = DATA_BITS + 1;
  localparam int WIDE_W    = 8;

  // Odd parity: the returned bit makes the total number of ones odd.
  function automatic logic odd_par(input logic [DATA_BITS-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic [NUM_BITS-1:0] tens_of(input logic [DATA_BITS-1:0] v);
    return NUM_BITS'(v / DATA_BITS'(10));
  endfunction

  function automatic logic [NUM_BITS-1:0] units_of(input logic [DATA_BITS-1:0] v);
    return NUM_BITS'(v % DATA_BITS'(10));
  endfunction

  function automatic logic [WIDE_W-1:0] dec_value(input logic [NUM_BITS-1:0] hi,
                                                  input logic [NUM_BITS-1:0] lo);
    return WIDE_W'(hi) * WIDE_W'(10) + WIDE_W'(lo);
  endfunction
endpackage

// File: rtl/bdc_b2d.sv
module bdc_b2d
  import bdc_pkg::*;
(
  input  logic [DATA_BITS-1:0] bin_i,
  output logic [DATA_BITS-1:0] hi_data_o,
  output logic [DATA_BITS-1:0] lo_data_o
);
  localparam int ZONE_W = DATA_BITS - NUM_BITS;

  // The zone bits are cleared as part of the result.
  assign hi_data_o = {{ZONE_W{1'b0}}, tens_of(bin_i)};
  assign lo_data_o = {{ZONE_W{1'b0}}, units_of(bin_i)};
endmodule

// File: rtl/bdc_d2b.sv
module bdc_d2b
  import bdc_pkg::*;
(
  input  logic [NUM_BITS-1:0]  hi_num_i,
  input  logic [NUM_BITS-1:0]  lo_num_i,
  output logic [DATA_BITS-1:0] hi_data_o,
  output logic [DATA_BITS-1:0] lo_data_o,
  output logic                 too_big_o
);
  logic [WIDE_W-1:0] value;

  assign value     = dec_value(hi_num_i, lo_num_i);
  assign lo_data_o = value[DATA_BITS-1:0];
  assign hi_data_o = '0;
  assign too_big_o = |value[WIDE_W-1:DATA_BITS];
endmodule

// File: rtl/bdc_ovf_reg.sv
module bdc_ovf_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set has priority over clear
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_o) && !$past(clr_i)) |-> flag_o);
  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i) && !$past(set_i)) |-> !flag_o);
  assert_ovf_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/bdc_converter.sv
module bdc_converter
  import bdc_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int LO_SLOT   = 3,
  parameter int HI_SLOT   = 4,
  localparam int ACC_W    = NUM_CHARS * CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             to_decimal,
  input  logic             clr_ovf,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             done,
  output logic             ovf_flag
);
  logic [CHAR_W-1:0]    lo_char_in, hi_char_in;
  logic [DATA_BITS-1:0] b2d_hi, b2d_lo, d2b_hi, d2b_lo;
  logic                 d2b_too_big;
  logic [DATA_BITS-1:0] new_hi_data, new_lo_data;
  logic [CHAR_W-1:0]    new_hi_char, new_lo_char;
  logic [ACC_W-1:0]     next_acc;
  logic                 ovf_set;

  assign lo_char_in = acc_in[LO_SLOT*CHAR_W +: CHAR_W];
  assign hi_char_in = acc_in[HI_SLOT*CHAR_W +: CHAR_W];

  bdc_b2d u_b2d (
    .bin_i     (lo_char_in[DATA_BITS-1:0]),
    .hi_data_o (b2d_hi),
    .lo_data_o (b2d_lo)
  );

  bdc_d2b u_d2b (
    .hi_num_i  (hi_char_in[NUM_BITS-1:0]),
    .lo_num_i  (lo_char_in[NUM_BITS-1:0]),
    .hi_data_o (d2b_hi),
    .lo_data_o (d2b_lo),
    .too_big_o (d2b_too_big)
  );

  assign new_hi_data = to_decimal ? b2d_hi : d2b_hi;
  assign new_lo_data = to_decimal ? b2d_lo : d2b_lo;
  assign new_hi_char = {odd_par(new_hi_data), new_hi_data};
  assign new_lo_char = {odd_par(new_lo_data), new_lo_data};
  assign ovf_set     = start && !to_decimal && d2b_too_big;

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_slot
    if (k == LO_SLOT) begin : g_lo
      assign next_acc[k*CHAR_W +: CHAR_W] = new_lo_char;
    end else if (k == HI_SLOT) begin : g_hi
      assign next_acc[k*CHAR_W +: CHAR_W] = new_hi_char;
    end else begin : g_keep
      assign next_acc[k*CHAR_W +: CHAR_W] = acc_in[k*CHAR_W +: CHAR_W];
      assert_keep_char_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> acc_out[k*CHAR_W +: CHAR_W] == $past(acc_in[k*CHAR_W +: CHAR_W]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) acc_out <= next_acc;
    end
  end

  bdc_ovf_reg u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovf_set),
    .clr_i  (clr_ovf),
    .flag_o (ovf_flag)
  );

  assert_odd_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((^acc_out[LO_SLOT*CHAR_W +: CHAR_W]) && (^acc_out[HI_SLOT*CHAR_W +: CHAR_W])));
  assert_zone_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(to_decimal)) |->
      (acc_out[LO_SLOT*CHAR_W+NUM_BITS +: 2] == 2'b00 &&
       acc_out[HI_SLOT*CHAR_W+NUM_BITS +: 2] == 2'b00));
  assert_hi_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(to_decimal)) |-> acc_out[HI_SLOT*CHAR_W +: DATA_BITS] == '0);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(acc_out));
  assert_no_flag_b2d_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(to_decimal) && !$past(clr_ovf)) |-> ovf_flag == $past(ovf_flag));
endmodule

// File: tb/test_bdc_converter.sv
module test_bdc_converter;
  localparam int AW = 56;
  logic clk = 0, rst_n = 0, start = 0, to_decimal = 0, clr_ovf = 0;
  logic [AW-1:0] acc_in = '0;
  logic [AW-1:0] acc_out;
  logic done, ovf_flag;
  int checks = 0, errors = 0;
  logic exp_ovf = 0;
  logic [AW-1:0] exp_acc = '0;

  always #4 clk = ~clk;

  bdc_converter i_bdc_converter (
    .clk(clk), .rst_n(rst_n), .start(start), .to_decimal(to_decimal),
    .clr_ovf(clr_ovf), .acc_in(acc_in), .acc_out(acc_out), .done(done),
    .ovf_flag(ovf_flag)
  );

  function automatic logic [6:0] mk_char(input logic [5:0] d);
    int ones = 0;
    for (int i = 0; i < 6; i++) ones += int'(d[i]);
    return {(ones % 2 == 0), d};
  endfunction

  function automatic logic [AW-1:0] model(input logic dir, input logic [AW-1:0] a,
                                          output logic big);
    logic [AW-1:0] r = a;
    int v, t, u;
    big = 0;
    if (dir) begin
      v = int'(a[21 +: 6]); t = 0;
      while (v >= 10) begin v -= 10; t++; end
      u = v;
      r[21 +: 7] = mk_char(6'(u));
      r[28 +: 7] = mk_char(6'(t));
    end else begin
      v = int'(a[28 +: 4]) * 10 + int'(a[21 +: 4]);
      big = (v > 63);
      r[21 +: 7] = mk_char(6'(v % 64));
      r[28 +: 7] = mk_char(6'd0);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic dir, input logic [AW-1:0] a, input logic clr);
    logic big;
    @(negedge clk);
    start = 1; to_decimal = dir; acc_in = a; clr_ovf = clr;
    exp_acc = model(dir, a, big);
    if (big) exp_ovf = 1;
    else if (clr) exp_ovf = 0;
    @(negedge clk);
    start = 0; clr_ovf = 0;
    chk(dir ? "R3/R9/R10 b2d word" : "R4/R5/R9/R10 d2b word", acc_out, exp_acc);
    chk("R2 done pulse", AW'(done), AW'(1));
    chk(dir ? "R8 flag after b2d" : "R6/R7 flag after d2b", AW'(ovf_flag), AW'(exp_ovf));
    acc_in = ~a;
    @(negedge clk);
    chk("R2 done low and word held", {AW'(done) ^ acc_out}, {AW'(0) ^ exp_acc});
  endtask

  function automatic logic [AW-1:0] with_slots(input logic [AW-1:0] a, input logic [6:0] lo,
                                               input logic [6:0] hi);
    logic [AW-1:0] r = a;
    r[21 +: 7] = lo; r[28 +: 7] = hi;
    return r;
  endfunction

  task automatic do_clear;
    @(negedge clk); clr_ovf = 1;
    @(negedge clk); clr_ovf = 0; exp_ovf = 0;
    chk("R7 flag cleared", AW'(ovf_flag), AW'(0));
  endtask

  logic finished = 0;
  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset word", acc_out, '0);
    chk("R1 reset flags", AW'({done, ovf_flag}), AW'(0));
    rst_n = 1;
    base = 56'h1A_2B3C_4D5E_6F70;
    // R3 corners: 0, 9, 10, 63, zones set on input
    do_op(1, with_slots(base, 7'h00, 7'h7F), 0);
    do_op(1, with_slots(base, 7'h09, 7'h00), 0);
    do_op(1, with_slots(base, 7'h0A, 7'h35), 0);
    do_op(1, with_slots(base, 7'h3F, 7'h3F), 0);
    // R4 corners: 63 fits, 64 overflows
    do_op(0, with_slots(base, 7'h33, 7'h36), 0);
    chk("R6 no flag at 63", AW'(ovf_flag), AW'(0));
    do_op(0, with_slots(base, 7'h04, 7'h06), 0);
    chk("R6 flag at 64", AW'(ovf_flag), AW'(1));
    // R8: b2d leaves flag set; R7 sticky across ops
    do_op(1, with_slots(base, 7'h2A, 7'h00), 0);
    do_op(0, with_slots(base, 7'h01, 7'h00), 0);
    do_clear;
    // R5 raw weight 15,15 -> 165, low 6 bits 37
    do_op(0, with_slots(base, 7'h0F, 7'h0F), 0);
    chk("R5 raw digit low slot", AW'(acc_out[21 +: 6]), AW'(37));
    // R7 set wins over simultaneous clear
    do_op(0, with_slots(base, 7'h09, 7'h09), 1);
    chk("R7 set beats clear", AW'(ovf_flag), AW'(1));
    do_clear;
    // R8: b2d with clear flag keeps it clear
    do_op(1, with_slots(base, 7'h3E, 7'h0F), 0);
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a = AW'({$urandom(), $urandom()});
      do_op(1'($urandom() % 2), a, 1'($urandom() % 8 == 0));
      if ($urandom() % 16 == 0) do_clear;
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule